// File: doc/BRIEF.md
# Audio FSK Bit Recovery Core

This core turns a stream of signed 8-bit audio samples carrying a two-tone (1200/2200 Hz) FSK signal into recovered data bits. Samples arrive on a strobe at 9600 Hz, so one bit lasts eight strobes. Each new sample is multiplied by the sample taken four strobes earlier. The sign of that product follows the tone, because the half-bit delay puts one tone roughly in phase and the other roughly out of phase. The product is smoothed by a first-order recursive lowpass filter whose coefficients are plain shifts, and the filter output is sliced on its sign.

A phase counter advances once per strobe and wraps once per bit period. Each transition in the sliced stream nudges the counter toward the middle of its range, so the wrap point settles near the centre of the received bits. At every wrap, a two-of-three vote over the newest sliced values decides the line level. The level is then NRZI-decoded: an unchanged level gives 1 and a changed level gives 0. The result leaves the core as a one-cycle valid pulse with a data bit. A parameter selects between two filter feedback variants.

Top module: `afsk_demod_core`

## Requirements
- R1: After a synchronous active-low reset, `bit_valid` and `bit_data` are 0, the four-entry delay line holds zeros, the filter state is 0, the phase counter is 0 and the previous decided level is 0.
- R2: All state advances only on clock edges where `smp_valid` is 1. Any number of cycles without a strobe changes neither the state nor the bit timing.
- R3: The discriminator value for a strobe is (current sample × sample from four strobes earlier) arithmetically shifted right by 2, held as 16-bit signed. For the first four strobes after reset the older operand is 0.
- R4: With `FB_MODE` = 0, the filter computes y = x_prev + x + (y_prev>>>1) + (y_prev>>>3) + (y_prev>>>5) in 16-bit signed arithmetic. x_prev is the previous discriminator value.
- R5: With `FB_MODE` = 1, the feedback is y_prev>>>1 alone.
- R6: The sliced value for a strobe is 1 when the new filter output is strictly greater than zero, otherwise 0.
- R7: The phase counter gains 8 per strobe. When the result reaches 64 or more, 64 is subtracted and a bit is decided. `bit_valid` is 1 for exactly the clock cycle after that strobe. With no transitions, a bit is decided on every eighth strobe.
- R8: When the newest two sliced values differ, the phase counter is first changed by +1 if it is below 32, otherwise by −1, and then the step of 8 is added.
- R9: The decided level is 1 when at least two of the three newest sliced values (including the current one) are 1.
- R10: `bit_data` is 1 when the decided level equals the previously decided level, otherwise 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | One-cycle strobe marking a new audio sample |
| smp_data | input | 8 | Signed audio sample |
| bit_valid | output | 1 | Pulses for one cycle per recovered bit |
| bit_data | output | 1 | NRZI-decoded recovered bit, valid with `bit_valid` |

## Verification
The hardest condition to reach from the ports is the phase correction. It acts only when a sliced transition lands at a known counter value, and it shows only as a shift in the strobe on which the next bit appears. A constant non-zero input applied straight after reset reaches it deterministically. The delay line holds zeros for four strobes, so the slice flips on the fifth strobe with the counter at exactly 32. The decrement branch then moves the first decision from strobe 8 to strobe 9. Tone sequences and a long pseudo-random sample stream, run against an independent per-sample model for both filter variants, cover the increment branch, ties in the vote and the remaining filter arithmetic.

// File: rtl/afsk_demod_pkg.sv
// Package: shared types and helpers for the audio FSK bit recovery core.
// Assumes: nothing beyond IEEE 1800-2017.
package afsk_demod_pkg;

    // Feedback variant of the lowpass filter.
    typedef enum logic [0:0] {
        FB_THREE_SHIFT = 1'b0,   // y/2 + y/8 + y/32 (about 0.66)
        FB_ONE_SHIFT   = 1'b1    // y/2 only
    } fb_mode_e;

    // Two-of-three majority over a 3-bit window.
    function automatic logic maj3(input logic [2:0] w);
        return (w[0] & w[1]) | (w[0] & w[2]) | (w[1] & w[2]);
    endfunction

endpackage

// File: rtl/afsk_delay_mult.sv
// Module: keeps the last DEPTH samples and forms the product of the current
// sample with the oldest one, arithmetically shifted right by PROD_SHIFT.
// Assumes: smp_valid is a single-cycle strobe; ACC_W >= 2*SMP_W.
module afsk_delay_mult #(
    parameter int SMP_W      = 8,
    parameter int DEPTH      = 4,
    parameter int ACC_W      = 16,
    parameter int PROD_SHIFT = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic signed [SMP_W-1:0] smp_data,
    output logic signed [ACC_W-1:0] prod
);

    logic signed [SMP_W-1:0] tap_q [DEPTH];
    logic signed [ACC_W-1:0] prod_full;

    // Shift register of past samples; reset loads zeros.
    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_tap
            if (i == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (!rst_n)         tap_q[0] <= '0;
                    else if (smp_valid) tap_q[0] <= smp_data;
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (!rst_n)         tap_q[i] <= '0;
                    else if (smp_valid) tap_q[i] <= tap_q[i-1];
                end
            end
        end
    endgenerate

    // Product of current and oldest sample, then arithmetic scaling.
    always_comb begin
        prod_full = ACC_W'(tap_q[DEPTH-1]) * ACC_W'(smp_data);
        prod      = prod_full >>> PROD_SHIFT;
    end

    AST_TAPS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (tap_q[DEPTH-1] == '0 && tap_q[0] == '0)); // R1

endmodule

// File: rtl/afsk_iir_slicer.sv
// Module: first-order recursive lowpass with shift-only feedback, followed
// by a sign slicer that keeps the three newest sliced values.
// Assumes: x_in is valid in the cycle smp_valid is high; wraps in ACC_W bits.
module afsk_iir_slicer
    import afsk_demod_pkg::*;
#(
    parameter int       ACC_W   = 16,
    parameter int       HIST_W  = 3,
    parameter fb_mode_e FB_MODE = FB_THREE_SHIFT
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic signed [ACC_W-1:0] x_in,
    output logic [HIST_W-1:0]       hist_next
);

    logic signed [ACC_W-1:0] x_q;
    logic signed [ACC_W-1:0] y_q;
    logic signed [ACC_W-1:0] fb;
    logic signed [ACC_W-1:0] y_next;
    logic [HIST_W-1:0]       hist_q;
    logic                    slice;

    // Feedback term selected by parameter.
    generate
        if (FB_MODE == FB_THREE_SHIFT) begin : g_fb3
            always_comb fb = (y_q >>> 1) + (y_q >>> 3) + (y_q >>> 5);
        end else begin : g_fb1
            always_comb fb = y_q >>> 1;
        end
    endgenerate

    // New filter output and its sign decision.
    always_comb begin
        y_next    = x_q + x_in + fb;
        slice     = !y_next[ACC_W-1] && (y_next != '0);
        hist_next = {hist_q[HIST_W-2:0], slice};
    end

    // Filter state and slice history update on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q    <= '0;
            y_q    <= '0;
            hist_q <= '0;
        end else if (smp_valid) begin
            x_q    <= x_in;
            y_q    <= y_next;
            hist_q <= hist_next;
        end
    end

    AST_HIST_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(hist_q) && $stable(y_q)); // R2

    AST_SLICE_FOLLOWS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> (hist_q[0] == (y_q > 0))); // R6

endmodule

// File: rtl/afsk_bit_sync.sv
// Module: phase counter that steps once per strobe, is nudged toward its
// midpoint on slice transitions, and on wrap votes a level and NRZI-decodes it.
// Assumes: hist_next[0] is the slice of the current strobe, [1] and [2] older.
module afsk_bit_sync
    import afsk_demod_pkg::*;
#(
    parameter int PH_W     = 8,
    parameter int SPB      = 8,
    parameter int PH_STEP  = 8,
    parameter int PH_NUDGE = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smp_valid,
    input  logic [2:0] hist_next,
    output logic       bit_valid,
    output logic       bit_data
);

    localparam int PH_FULL_I = SPB * PH_STEP;
    localparam int PH_HALF_I = PH_FULL_I / 2;
    localparam logic signed [PH_W-1:0] FULL_C  = PH_W'(PH_FULL_I);
    localparam logic signed [PH_W-1:0] HALF_C  = PH_W'(PH_HALF_I);
    localparam logic signed [PH_W-1:0] STEP_C  = PH_W'(PH_STEP);
    localparam logic signed [PH_W-1:0] NUDGE_C = PH_W'(PH_NUDGE);

    logic signed [PH_W-1:0] ph_q;
    logic signed [PH_W-1:0] ph_adj;
    logic signed [PH_W-1:0] ph_sum;
    logic signed [PH_W-1:0] ph_d;
    logic                   edge_seen;
    logic                   wrap;
    logic                   level;
    logic                   prev_level_q;

    // Edge nudge, per-strobe step and modulo wrap.
    always_comb begin
        edge_seen = hist_next[0] ^ hist_next[1];
        if (edge_seen) ph_adj = (ph_q < HALF_C) ? ph_q + NUDGE_C : ph_q - NUDGE_C;
        else           ph_adj = ph_q;
        ph_sum = ph_adj + STEP_C;
        wrap   = (ph_sum >= FULL_C);
        ph_d   = wrap ? ph_sum - FULL_C : ph_sum;
        level  = maj3(hist_next);
    end

    // Phase, previous level and registered bit output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q         <= '0;
            prev_level_q <= 1'b0;
            bit_valid    <= 1'b0;
            bit_data     <= 1'b0;
        end else begin
            bit_valid <= smp_valid && wrap;
            if (smp_valid) begin
                ph_q <= ph_d;
                if (wrap) begin
                    prev_level_q <= level;
                    bit_data     <= (level == prev_level_q);
                end
            end
        end
    end

    AST_PHASE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q >= 0) && (ph_q < FULL_C)); // R7

    AST_PHASE_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(ph_q) && !bit_valid); // R2

    AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> $past(smp_valid)); // R7

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |=> !bit_valid); // R7

endmodule

// File: rtl/afsk_demod_core.sv
// Module: top of the audio FSK bit recovery core: delay-multiply
// discriminator, shift-coefficient lowpass with slicer, and bit sync.
// Assumes: samples are signed, one strobe per sample, eight strobes per bit.
module afsk_demod_core
    import afsk_demod_pkg::*;
#(
    parameter int       SMP_W      = 8,
    parameter int       ACC_W      = 16,
    parameter int       SPB        = 8,
    parameter int       PROD_SHIFT = 2,
    parameter int       PH_W       = 8,
    parameter int       PH_STEP    = 8,
    parameter int       PH_NUDGE   = 1,
    parameter fb_mode_e FB_MODE    = FB_THREE_SHIFT
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic signed [SMP_W-1:0] smp_data,
    output logic                    bit_valid,
    output logic                    bit_data
);

    localparam int HALF_BIT = SPB / 2;

    logic signed [ACC_W-1:0] disc;
    logic [2:0]              hist_next;

    afsk_delay_mult #(
        .SMP_W(SMP_W), .DEPTH(HALF_BIT), .ACC_W(ACC_W), .PROD_SHIFT(PROD_SHIFT)
    ) u_disc (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .smp_data(smp_data), .prod(disc)
    );

    afsk_iir_slicer #(
        .ACC_W(ACC_W), .HIST_W(3), .FB_MODE(FB_MODE)
    ) u_filt (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .x_in(disc), .hist_next(hist_next)
    );

    afsk_bit_sync #(
        .PH_W(PH_W), .SPB(SPB), .PH_STEP(PH_STEP), .PH_NUDGE(PH_NUDGE)
    ) u_sync (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .hist_next(hist_next), .bit_valid(bit_valid), .bit_data(bit_data)
    );

endmodule

// File: tb/afsk_demod_core_test.sv
// Bench: directed scenarios against a per-sample behavioural model of the
// requirements, applied to both filter variants at once.
module afsk_demod_core_test;
    import afsk_demod_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_valid = 1'b0;
    logic signed [7:0] smp_data = '0;
    logic              bv [2];
    logic              bd [2];

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;  // 50 MHz

    afsk_demod_core #(.FB_MODE(FB_THREE_SHIFT)) uut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .bit_valid(bv[0]), .bit_data(bd[0]));

    afsk_demod_core #(.FB_MODE(FB_ONE_SHIFT)) uut_alt (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .bit_valid(bv[1]), .bit_data(bd[1]));

    // Behavioural model state
    int      m_dl [4];
    shortint m_x [2];
    shortint m_y [2];
    int      m_ph [2];
    bit [2:0] m_h [2];
    bit      m_pv [2];
    bit      e_v [2];
    bit      e_d [2];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) m_dl[i] = 0;
        for (int m = 0; m < 2; m++) begin
            m_x[m] = 0; m_y[m] = 0; m_ph[m] = 0; m_h[m] = 0; m_pv[m] = 0;
        end
    endtask

    task automatic model_step(input int s);
        int prod;
        prod = (m_dl[3] * s) >>> 2;
        for (int i = 3; i > 0; i--) m_dl[i] = m_dl[i-1];
        m_dl[0] = s;
        for (int m = 0; m < 2; m++) begin
            int yp, fbk, yn;
            bit vote;
            yp  = int'(m_y[m]);
            fbk = (m == 0) ? (yp >>> 1) + (yp >>> 3) + (yp >>> 5) : (yp >>> 1);
            yn  = int'(m_x[m]) + prod + fbk;
            m_y[m] = shortint'(yn);
            m_x[m] = shortint'(prod);
            m_h[m] = {m_h[m][1:0], (m_y[m] > 0)};
            if (m_h[m][0] != m_h[m][1]) m_ph[m] += (m_ph[m] < 32) ? 1 : -1;
            m_ph[m] += 8;
            e_v[m] = 0;
            if (m_ph[m] >= 64) begin
                m_ph[m] -= 64;
                e_v[m] = 1;
                vote = ($countones(m_h[m]) >= 2);
                e_d[m] = (vote == m_pv[m]);
                m_pv[m] = vote;
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; smp_valid = 1'b0; smp_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
    endtask

    // One strobe; compares both instances with the model, then one idle cycle.
    task automatic push(input int s, input string tag, output bit got_v, output bit got_d);
        @(negedge clk);
        smp_valid = 1'b1; smp_data = 8'(s);
        model_step(s);
        @(negedge clk);
        smp_valid = 1'b0;
        for (int m = 0; m < 2; m++) begin
            check(bv[m] == e_v[m], $sformatf("%s valid inst%0d", tag, m), bv[m], e_v[m]);
            if (e_v[m])
                check(bd[m] == e_d[m], $sformatf("%s data inst%0d", tag, m), bd[m], e_d[m]);
        end
        got_v = bv[0]; got_d = bd[0];
        @(negedge clk);
        check(bv[0] == 1'b0, {tag, " R7 pulse one cycle"}, bv[0], 0);
    endtask

    task automatic test_reset();
        do_reset();
        check(bv[0] == 0 && bv[1] == 0, "R1 bit_valid after reset", bv[0], 0);
        check(bd[0] == 0 && bd[1] == 0, "R1 bit_data after reset", bd[0], 0);
    endtask

    task automatic test_zero_input();
        bit v, d;
        int nv = 0;
        do_reset();
        for (int k = 1; k <= 16; k++) begin
            push(0, "R7 zero input", v, d);
            if (v) begin
                nv++;
                check(k % 8 == 0, "R7 decision every 8th strobe", k, 8 * nv);
                check(d == 1'b1, "R10 steady level gives 1", d, 1);
            end
        end
        check(nv == 2, "R7 bit count for 16 strobes", nv, 2);
    endtask

    task automatic test_idle_gaps();
        bit v, d;
        int first = 0;
        do_reset();
        for (int k = 1; k <= 8; k++) begin
            if (k == 5) begin
                for (int g = 0; g < 30; g++) begin
                    @(negedge clk);
                    check(bv[0] == 0, "R2 no output while idle", bv[0], 0);
                end
            end
            push(0, "R2 idle gaps", v, d);
            if (v && first == 0) first = k;
        end
        check(first == 8, "R2 gaps do not move timing", first, 8);
    endtask

    task automatic test_dc_step();
        bit v, d;
        int first = 0, second = 0;
        bit d1 = 0, d2 = 0;
        do_reset();
        for (int k = 1; k <= 17; k++) begin
            push(40, "R3 R8 dc step", v, d);
            if (v && first == 0) begin first = k; d1 = d; end
            else if (v && second == 0) begin second = k; d2 = d; end
        end
        check(first == 9, "R8 edge at phase 32 decrements, first bit", first, 9);
        check(d1 == 1'b0, "R10 level change gives 0", d1, 0);
        check(second == 17, "R7 next bit one period later", second, 17);
        check(d2 == 1'b1, "R9 R6 positive slices vote 1, unchanged gives 1", d2, 1);
    endtask

    task automatic test_tones();
        bit v, d;
        real acc = 0.0;
        bit [39:0] pat = 40'hA5_3C_F0_96_1E;
        bit tone = 0;
        do_reset();
        for (int b = 0; b < 40; b++) begin
            if (!pat[b]) tone = ~tone;
            for (int s = 0; s < 8; s++) begin
                acc += tone ? 2200.0 / 9600.0 : 1200.0 / 9600.0;
                if (acc >= 1.0) acc -= 1.0;
                push(int'(100.0 * $sin(2.0 * 3.14159265 * acc)), "R4 R5 R9 R10 tones", v, d);
            end
        end
    endtask

    task automatic test_random();
        bit v, d;
        logic [15:0] lfsr = 16'hACE1;
        do_reset();
        for (int k = 0; k < 1500; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            push(int'($signed(lfsr[7:0])), "R3 R4 R5 R6 R8 random", v, d);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        test_reset();
        test_zero_input();
        test_idle_gaps();
        test_dc_step();
        test_tones();
        test_random();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule